// File: doc/BRIEF.md
# Vector Multiply-Subtract Unit with Split Wide Results

This block applies a multiply-subtract to every element of a vector, one element at a time. A 64-bit scalar multiplier is taken at start and held for the whole vector. For element i, the unit reads two 64-bit operands from a feed port: a multiplicand `op_a` and a minuend `op_c`. It forms the full 128-bit unsigned product of the scalar and `op_a`, zero-extends `op_c` to 128 bits, and subtracts the product from it modulo 2^128.

The 128-bit difference is never truncated. Its lower half goes to register `base+i` and its upper half to register `base+len+i`, so one vector operation fills two register vectors that sit `len` registers apart. The unit issues these as two write-port beats per element, lower half first. It raises a one-cycle completion pulse after the final beat.

Each element takes three cycles: an operand fetch that captures the difference, the lower-half write, and the upper-half write. Register storage, decode and masking are outside this block.

Top module: `vmsub_unit`

## Requirements
- R1: After reset, `wr_en`, `done`, `busy` and `op_req` are all 0.
- R2: The data of the first write for element i is bits 63:0 of ({64'b0, c_i} - s * a_i) mod 2^128, where s is the scalar and the product is the full 128-bit unsigned product.
- R3: The data of the second write for element i is bits 127:64 of that same 128-bit difference, including the borrow when the product exceeds c_i.
- R4: The first write for element i targets index (base + i) mod 64, and the second targets (base + len + i) mod 64, on the 6-bit `wr_idx`.
- R5: For each element, the lower-half write is followed by the upper-half write in the next cycle. Elements are written in ascending order of i, and exactly 2*len writes occur per operation.
- R6: The unit raises `op_req` for exactly one cycle per element, with `op_idx` taking 0, 1, ..., len-1 in order. The scalar captured at start is used for every element, even if `scalar` changes afterwards.
- R7: A start with `len` = 0 produces no writes, and `done` is high in the first cycle after the start edge.
- R8: `done` is high for exactly one cycle, the cycle after the last upper-half write. For len elements, this is the (3*len+1)-th cycle after the start edge.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running operation's writes are unchanged, and no further writes follow its `done`.
- R10: A `len` input above 16 is treated as 16.
- R11: `busy` is high from the cycle after an accepted start through the `done` cycle, and `wr_en` is only high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| len | input | 5 | Vector length, 0 to 16; larger values are clamped to 16 |
| base | input | 6 | Destination register index for element 0's lower half |
| scalar | input | 64 | Scalar multiplier, captured at start |
| op_req | output | 1 | Operand fetch strobe for the current element |
| op_idx | output | 4 | Element index being fetched |
| op_a | input | 64 | Multiplicand for element `op_idx`, valid while `op_req` is high |
| op_c | input | 64 | Minuend for element `op_idx`, valid while `op_req` is high |
| wr_en | output | 1 | Register write enable |
| wr_idx | output | 6 | Register write index |
| wr_data | output | 64 | Register write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check the following:
- `done` lasts a single cycle.
- Writes occur only while busy.
- An upper-half beat always follows a lower-half beat, and its index sits exactly `len` above that beat's index.
- The element counter stays below the latched length.
- The latched length holds for the whole operation.

The arithmetic values, the wraparound of the register index, the clamping of long vectors, the exact cycle of `done`, and the rejection of a start during an operation can only be shown by the bench's scenarios. Each scenario compares the whole write stream against its own independently computed expectations.

// File: rtl/vmsub_pkg.sv
package vmsub_pkg;
  localparam int XLEN  = 64;
  localparam int WIDE  = 2 * XLEN;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WLO,
    S_WHI,
    S_DONE
  } vmsub_state_t;

  // Full-width product subtracted from a zero-extended minuend, modulo 2^WIDE.
  function automatic logic [WIDE-1:0] msub_wide(input logic [XLEN-1:0] s,
                                                input logic [XLEN-1:0] a,
                                                input logic [XLEN-1:0] c);
    logic [WIDE-1:0] prod;
    prod = WIDE'(s) * WIDE'(a);
    return WIDE'(c) - prod;
  endfunction
endpackage

// File: rtl/vmsub_ctrl.sv
module vmsub_ctrl
  import vmsub_pkg::*;
#(
  parameter int MAXVL = 16,
  parameter int VLW   = 5,
  parameter int ELW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] len,
  output logic           accept,
  output logic           cap,
  output logic           wr_lo,
  output logic           wr_hi,
  output logic           busy,
  output logic           done,
  output logic [ELW-1:0] elem,
  output logic [VLW-1:0] vl_q
);
  vmsub_state_t state;
  logic [VLW-1:0] vl_eff;
  logic           last;

  assign vl_eff = (len > VLW'(MAXVL)) ? VLW'(MAXVL) : len;
  assign accept = start && (state == S_IDLE);
  assign cap    = (state == S_FETCH);
  assign wr_lo  = (state == S_WLO);
  assign wr_hi  = (state == S_WHI);
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_DONE);
  assign last   = (VLW'(elem) + VLW'(1)) == vl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      elem  <= '0;
      vl_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          vl_q  <= vl_eff;
          elem  <= '0;
          state <= (vl_eff == '0) ? S_DONE : S_FETCH;
        end
        S_FETCH: state <= S_WLO;
        S_WLO:   state <= S_WHI;
        S_WHI: begin
          if (last) state <= S_DONE;
          else begin
            elem  <= elem + ELW'(1);
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_LO_THEN_HI: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> wr_hi); // R5
  AST_ELEM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cap || wr_lo || wr_hi) |-> (VLW'(elem) < vl_q)); // R10
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(vl_q)); // R9
endmodule

// File: rtl/vmsub_dp.sv
module vmsub_dp
  import vmsub_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            cap,
  input  logic [XLEN-1:0] scalar,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_c,
  output logic [WIDE-1:0] diff_q
);
  logic [XLEN-1:0] scalar_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scalar_q <= '0;
      diff_q   <= '0;
    end else begin
      if (accept) scalar_q <= scalar;
      if (cap)    diff_q   <= msub_wide(scalar_q, op_a, op_c);
    end
  end
endmodule

// File: rtl/vmsub_wport.sv
module vmsub_wport
  import vmsub_pkg::*;
#(
  parameter int IDXW = 6,
  parameter int VLW  = 5,
  parameter int ELW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            busy,
  input  logic [IDXW-1:0] base,
  input  logic [VLW-1:0]  vl_q,
  input  logic [ELW-1:0]  elem,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [WIDE-1:0] diff,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [XLEN-1:0] wr_data
);
  logic [IDXW-1:0] base_q;
  logic [IDXW-1:0] lo_idx;
  logic [IDXW-1:0] hi_idx;

  always_ff @(posedge clk) begin
    if (!rst_n)      base_q <= '0;
    else if (accept) base_q <= base;
  end

  assign lo_idx  = base_q + IDXW'(elem);
  assign hi_idx  = lo_idx + IDXW'(vl_q);
  assign wr_en   = wr_lo || wr_hi;
  assign wr_idx  = wr_hi ? hi_idx : lo_idx;
  assign wr_data = wr_hi ? diff[WIDE-1:XLEN] : diff[XLEN-1:0];

  AST_HI_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |-> (wr_idx == IDXW'($past(wr_idx) + IDXW'(vl_q)))); // R4
  AST_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy); // R11
endmodule

// File: rtl/vmsub_unit.sv
module vmsub_unit
  import vmsub_pkg::*;
#(
  parameter int MAXVL = 16,
  parameter int IDXW  = 6,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int ELW  = $clog2(MAXVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  len,
  input  logic [IDXW-1:0] base,
  input  logic [XLEN-1:0] scalar,
  output logic            op_req,
  output logic [ELW-1:0]  op_idx,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_c,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [XLEN-1:0] wr_data,
  output logic            busy,
  output logic            done
);
  logic            accept, cap, wr_lo, wr_hi;
  logic [ELW-1:0]  elem;
  logic [VLW-1:0]  vl_q;
  logic [WIDE-1:0] diff;

  vmsub_ctrl #(.MAXVL(MAXVL), .VLW(VLW), .ELW(ELW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len),
    .accept(accept), .cap(cap), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .busy(busy), .done(done), .elem(elem), .vl_q(vl_q)
  );

  vmsub_dp u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cap(cap),
    .scalar(scalar), .op_a(op_a), .op_c(op_c), .diff_q(diff)
  );

  vmsub_wport #(.IDXW(IDXW), .VLW(VLW), .ELW(ELW)) u_wport (
    .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy),
    .base(base), .vl_q(vl_q), .elem(elem),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .diff(diff),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  assign op_req = cap;
  assign op_idx = elem;
endmodule

// File: tb/vmsub_unit_bench.sv
module vmsub_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  len = '0;
  logic [5:0]  base = '0;
  logic [63:0] scalar = '0;
  logic        op_req;
  logic [3:0]  op_idx;
  logic [63:0] op_a, op_c;
  logic        wr_en;
  logic [5:0]  wr_idx;
  logic [63:0] wr_data;
  logic        busy, done;

  logic [63:0] a_mem [16];
  logic [63:0] c_mem [16];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign op_a = a_mem[op_idx];
  assign op_c = c_mem[op_idx];

  vmsub_unit u_vmsub_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len), .base(base),
    .scalar(scalar), .op_req(op_req), .op_idx(op_idx), .op_a(op_a),
    .op_c(op_c), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish (got hang, expected completion)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Expected 128-bit difference via two's-complement add of the negated product.
  function automatic logic [127:0] ref_diff(logic [63:0] s, logic [63:0] a, logic [63:0] c);
    logic [127:0] p;
    p = {64'b0, s} * {64'b0, a};
    return {64'b0, c} + (~p + 128'd1);
  endfunction

  // Runs one operation and checks the full write stream. poke issues a start mid-run.
  task automatic run_op(string name, int n_in, logic [5:0] b, logic [63:0] s, bit poke);
    int n, cyc, nw, nreq, last_wr, done_cyc;
    logic [5:0]  widx [32];
    logic [63:0] wdat [32];
    n = (n_in > 16) ? 16 : n_in;
    nw = 0; nreq = 0; last_wr = 0; done_cyc = -1;
    @(negedge clk);
    len = 5'(n_in); base = b; scalar = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    scalar = ~s;          // R6: later scalar changes must not matter
    for (cyc = 1; cyc < 60; cyc++) begin
      if (cyc > 1) @(negedge clk);
      if (cyc == 1) chk({"R11 busy after start ", name}, 128'(busy), 128'(1));
      if (poke && cyc == 2) begin len = 5'd3; base = 6'd9; start = 1'b1; end
      if (poke && cyc == 3) start = 1'b0;
      if (op_req) begin
        chk({"R6 op_idx order ", name}, 128'(op_idx), 128'(nreq));
        nreq++;
      end
      if (wr_en) begin
        if (nw < 32) begin widx[nw] = wr_idx; wdat[nw] = wr_data; end
        nw++; last_wr = cyc;
      end
      if (done) begin done_cyc = cyc; break; end
    end
    chk({"R5 write count ", name}, 128'(nw), 128'(2 * n));
    chk({"R6 fetch count ", name}, 128'(nreq), 128'(n));
    chk({"R8 done cycle ", name}, 128'(done_cyc), 128'(3 * n + 1));
    if (n > 0) chk({"R8 done after last write ", name}, 128'(done_cyc), 128'(last_wr + 1));
    for (int i = 0; i < n && 2 * i + 1 < nw; i++) begin
      logic [127:0] d;
      d = ref_diff(s, a_mem[i], c_mem[i]);
      chk({"R2 low data ", name}, 128'(wdat[2*i]), 128'(d[63:0]));
      chk({"R3 high data ", name}, 128'(wdat[2*i+1]), 128'(d[127:64]));
      chk({"R4 low index ", name}, 128'(widx[2*i]), 128'(6'(b + 6'(i))));
      chk({"R4 high index ", name}, 128'(widx[2*i+1]), 128'(6'(b + 6'(n) + 6'(i))));
    end
    @(negedge clk);
    chk({"R8 done one cycle ", name}, 128'(done), 128'(0));
    nw = 0;
    for (int k = 0; k < 4; k++) begin
      if (wr_en) nw++;
      @(negedge clk);
    end
    chk({"R9 no trailing writes ", name}, 128'(nw), 128'(0));
    chk({"R11 idle after done ", name}, 128'(busy), 128'(0));
  endtask

  task automatic t_reset();
    chk("R1 wr_en at reset", 128'(wr_en), 128'(0));
    chk("R1 done at reset", 128'(done), 128'(0));
    chk("R1 busy at reset", 128'(busy), 128'(0));
    chk("R1 op_req at reset", 128'(op_req), 128'(0));
  endtask

  task automatic fill(int seed);
    for (int i = 0; i < 16; i++) begin
      a_mem[i] = {32'(seed * 7 + i * 3 + 1), 32'(seed + i * 1009)};
      c_mem[i] = {32'(seed * 13 + i), 32'(i * 77 + 5)};
    end
  endtask

  task automatic t_basic();  fill(3);  run_op("basic", 4, 6'd2, 64'h0000_0001_2345_6789, 1'b0); endtask
  task automatic t_single(); fill(11); a_mem[0] = 64'd5; c_mem[0] = 64'd100;
                             run_op("single no borrow", 1, 6'd0, 64'd3, 1'b0); endtask
  task automatic t_extreme(); // R3 borrow with all-ones operands and zero minuend
    fill(1);
    a_mem[0] = '1; c_mem[0] = '0; a_mem[1] = '1; c_mem[1] = '1;
    run_op("extreme", 2, 6'd20, '1, 1'b0);
  endtask
  task automatic t_wrap();   fill(5);  run_op("full wrap", 16, 6'd50, 64'hdead_beef_0bad_f00d, 1'b0); endtask
  task automatic t_zero();   fill(2);  run_op("R7 zero length", 0, 6'd7, 64'd9, 1'b0); endtask
  task automatic t_busy();   fill(8);  run_op("R9 start while busy", 5, 6'd30, 64'h1234, 1'b1); endtask
  task automatic t_clamp();  fill(4);  run_op("R10 clamp", 20, 6'd1, 64'h77, 1'b0); endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_single();
    t_extreme();
    t_wrap();
    t_zero();
    t_busy();
    t_clamp();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule